// File: doc/BRIEF.md
# Framebuffer-to-Page Refresh Engine

This block copies a byte-per-pixel framebuffer of 128 columns by 128 rows into a monochrome OLED controller whose memory is organised in horizontal pages, each eight pixel rows tall. A single-cycle request starts a refresh. The engine walks the panel one page at a time. For each page it first writes a short cursor command. It then reads the framebuffer through a synchronous RAM port with one cycle of read latency. From each column it gathers eight vertically adjacent pixels into one byte and writes that byte over an 8-bit parallel write bus. The bus has an active-low chip select, a register-select line and an active-low write strobe.

A frame is 16 pages, and each page is three command bytes followed by 128 data bytes. When the last byte of page 15 has been written, the engine pulses `done` for one clock and returns to idle. A request that arrives while a refresh is running is remembered, and one further complete refresh follows. The setup and strobe widths of every bus write are parameters, so the bus can be matched to the panel's timing.

Top module: `fb_page_refresh`

## Requirements
- R1: While reset is asserted and after it is released with no request, chip select and write strobe are high (inactive), and `busy` and `done` are low.
- R2: Pages are written in order 0 to 15. Before each page's data, three command bytes are written with register-select low: 0xB0 OR the page number, then 0x10, then 0x00 (column reset to 0).
- R3: After the command bytes, each page carries exactly 128 data bytes with register-select high, for columns 0, 1, ... 127 in that order.
- R4: The data byte for page p, column x takes bit 7 from framebuffer row 8p and bit 0 from row 8p+7, all at column x. Pixel (row r, column c) is read from RAM address r*128+c, and read data is valid one clock after the address.
- R5: A framebuffer byte counts as a lit pixel (bit 1) when it is nonzero, whatever its value, and as unlit (bit 0) when it is zero.
- R6: Every bus write has the same timing. Chip select goes low with the byte already on the bus. The strobe stays high for ADDR_SETUP clocks, then stays low for DATA_SETUP clocks, then rises while chip select is still low. Data and register-select stay stable until chip select is released one clock later, and chip select is high between bytes.
- R7: `busy` goes high two clocks after a request is sampled and stays high until `done`. `done` is a one-clock pulse issued only after all 2096 bytes of the frame, and `busy` is low in the clock after it.
- R8: One or more requests arriving during a refresh cause exactly one further full refresh after `done`. No request means no further refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refreshReq | input | 1 | One-clock request to copy the framebuffer |
| busy | output | 1 | A refresh is in progress |
| done | output | 1 | One-clock pulse when the frame is complete |
| ramAddr | output | 14 | Framebuffer read address (row*128+column) |
| ramRdEn | output | 1 | Framebuffer read enable |
| ramRdData | input | 8 | Framebuffer read data, one clock after the address |
| lcdCsN | output | 1 | Panel chip select, active low |
| lcdDc | output | 1 | Register select: 0 command, 1 data |
| lcdWrN | output | 1 | Panel write strobe, active low |
| lcdData | output | 8 | Panel data bus |

## Verification
The bus assertions assume the clocks of a write are counted only while reset is released. They also assume that chip select and strobe reach their idle level out of reset, so every strobe edge they measure belongs to a transfer that started after reset. The framebuffer model answers every read one clock later with a value computed from the address. The model is valid for any address the engine can produce, and requests are single-clock pulses. The patterns change only between frames, so each frame is compared against one consistent image. Single-bit nonzero values, full diagonals and sparse patterns are used so that bit order, the nonzero rule and address arithmetic each show up in the bytes.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  // Rows gathered into one panel byte; fixed by the byte width of the bus.
  localparam int PAGE_ROWS = 8;
  localparam int CMD_BYTES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD_LOAD,
    ST_GATHER,
    ST_DATA_LOAD,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_FINISH
  } fbrState_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic       issueRead;   // present a framebuffer address this cycle
    logic       captureBit;  // read data of the previous cycle is valid
    logic       loadCmd;     // put command byte cmdIdx on the bus
    logic [1:0] cmdIdx;
    logic       loadData;    // put the gathered byte on the bus
    logic       csActive;    // chip select asserted next cycle
    logic       wrActive;    // write strobe asserted next cycle
  } fbrStrobes_t;

endpackage

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
#(
  parameter int COLS       = 128,
  parameter int PAGES      = 16,
  parameter int ADDR_SETUP = 10,
  parameter int DATA_SETUP = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     refreshReq,
  output fbrStrobes_t              strobes,
  output logic [$clog2(PAGES)-1:0] page,
  output logic [$clog2(COLS)-1:0]  col,
  output logic [$clog2(PAGE_ROWS)-1:0] row,
  output logic                     busy,
  output logic                     done
);

  localparam int PAGE_W  = $clog2(PAGES);
  localparam int COL_W   = $clog2(COLS);
  localparam int ROW_W   = $clog2(PAGE_ROWS);
  localparam int GCNT_W  = ROW_W + 1;
  localparam int PH_MAX  = (ADDR_SETUP > DATA_SETUP) ? ADDR_SETUP : DATA_SETUP;
  localparam int PH_W    = $clog2(PH_MAX + 1);

  fbrState_t         state;
  logic [GCNT_W-1:0] gatherCnt;
  logic [PH_W-1:0]   phaseCnt;
  logic [1:0]        cmdIdx;
  logic              isData;
  logic              pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      page      <= '0;
      col       <= '0;
      gatherCnt <= '0;
      phaseCnt  <= '0;
      cmdIdx    <= '0;
      isData    <= 1'b0;
      pending   <= 1'b0;
    end else begin
      // A request is remembered until the idle state consumes it.
      pending <= refreshReq | (pending & (state != ST_IDLE));
      unique case (state)
        ST_IDLE: begin
          if (pending) begin
            page   <= '0;
            col    <= '0;
            cmdIdx <= '0;
            state  <= ST_CMD_LOAD;
          end
        end
        ST_CMD_LOAD: begin
          isData   <= 1'b0;
          phaseCnt <= '0;
          state    <= ST_SETUP;
        end
        ST_GATHER: begin
          if (gatherCnt == GCNT_W'(PAGE_ROWS)) begin
            state <= ST_DATA_LOAD;
          end else begin
            gatherCnt <= gatherCnt + 1'b1;
          end
        end
        ST_DATA_LOAD: begin
          isData   <= 1'b1;
          phaseCnt <= '0;
          state    <= ST_SETUP;
        end
        ST_SETUP: begin
          if (phaseCnt == PH_W'(ADDR_SETUP - 1)) begin
            phaseCnt <= '0;
            state    <= ST_STROBE;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_STROBE: begin
          if (phaseCnt == PH_W'(DATA_SETUP - 1)) begin
            phaseCnt <= '0;
            state    <= ST_HOLD;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (!isData) begin
            if (cmdIdx == 2'(CMD_BYTES - 1)) begin
              col       <= '0;
              gatherCnt <= '0;
              state     <= ST_GATHER;
            end else begin
              cmdIdx <= cmdIdx + 1'b1;
              state  <= ST_CMD_LOAD;
            end
          end else if (col == COL_W'(COLS - 1)) begin
            if (page == PAGE_W'(PAGES - 1)) begin
              state <= ST_FINISH;
            end else begin
              page   <= page + 1'b1;
              col    <= '0;
              cmdIdx <= '0;
              state  <= ST_CMD_LOAD;
            end
          end else begin
            col       <= col + 1'b1;
            gatherCnt <= '0;
            state     <= ST_GATHER;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.cmdIdx     = cmdIdx;
    strobes.issueRead  = (state == ST_GATHER) && (gatherCnt < GCNT_W'(PAGE_ROWS));
    strobes.captureBit = (state == ST_GATHER) && (gatherCnt != '0);
    strobes.loadCmd    = (state == ST_CMD_LOAD);
    strobes.loadData   = (state == ST_DATA_LOAD);
    strobes.csActive   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    strobes.wrActive   = (state == ST_STROBE);
  end

  assign row  = gatherCnt[ROW_W-1:0];
  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

endmodule

// File: rtl/fbr_datapath.sv
module fbr_datapath
  import fbr_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int PAGES = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  fbrStrobes_t                       strobes,
  input  logic [$clog2(PAGES)-1:0]          page,
  input  logic [$clog2(COLS)-1:0]           col,
  input  logic [$clog2(PAGE_ROWS)-1:0]      row,
  output logic [$clog2(COLS*PAGES*PAGE_ROWS)-1:0] ramAddr,
  output logic                              ramRdEn,
  input  logic [7:0]                        ramRdData,
  output logic                              lcdCsN,
  output logic                              lcdDc,
  output logic                              lcdWrN,
  output logic [7:0]                        lcdData
);

  localparam int ADDR_W = $clog2(COLS * PAGES * PAGE_ROWS);

  logic [ADDR_W-1:0]    lineIdx;
  logic [PAGE_ROWS-1:0] gather;
  logic [7:0]           colWide;
  logic [7:0]           cmdByte;

  // Framebuffer row = page*8 + row; address = row*COLS + column.
  always_comb begin
    lineIdx = ADDR_W'(page) * ADDR_W'(PAGE_ROWS) + ADDR_W'(row);
    ramAddr = lineIdx * ADDR_W'(COLS) + ADDR_W'(col);
    ramRdEn = strobes.issueRead;
  end

  // Cursor command bytes: page select, column high bits, column low nibble.
  always_comb begin
    colWide = 8'(col);
    unique case (strobes.cmdIdx)
      2'd0:    cmdByte = 8'hB0 | {4'h0, 4'(page)};
      2'd1:    cmdByte = 8'h10 | {5'b0, colWide[6:4]};
      default: cmdByte = {4'h0, colWide[3:0]};
    endcase
  end

  // First row read lands in bit 7 after eight shifts.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gather <= '0;
    end else if (strobes.captureBit) begin
      gather <= {gather[PAGE_ROWS-2:0], (ramRdData != 8'h00)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lcdCsN  <= 1'b1;
      lcdWrN  <= 1'b1;
      lcdDc   <= 1'b0;
      lcdData <= 8'h00;
    end else begin
      lcdCsN <= ~strobes.csActive;
      lcdWrN <= ~strobes.wrActive;
      if (strobes.loadCmd) begin
        lcdDc   <= 1'b0;
        lcdData <= cmdByte;
      end else if (strobes.loadData) begin
        lcdDc   <= 1'b1;
        lcdData <= gather;
      end
    end
  end

endmodule

// File: rtl/fb_page_refresh.sv
module fb_page_refresh
  import fbr_pkg::*;
#(
  parameter int COLS       = 128,
  parameter int PAGES      = 16,
  parameter int ADDR_SETUP = 10,
  parameter int DATA_SETUP = 10
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    refreshReq,
  output logic                                    busy,
  output logic                                    done,
  output logic [$clog2(COLS*PAGES*PAGE_ROWS)-1:0] ramAddr,
  output logic                                    ramRdEn,
  input  logic [7:0]                              ramRdData,
  output logic                                    lcdCsN,
  output logic                                    lcdDc,
  output logic                                    lcdWrN,
  output logic [7:0]                              lcdData
);

  fbrStrobes_t                 strobes;
  logic [$clog2(PAGES)-1:0]    page;
  logic [$clog2(COLS)-1:0]     col;
  logic [$clog2(PAGE_ROWS)-1:0] row;

  fbr_ctrl #(
    .COLS(COLS), .PAGES(PAGES),
    .ADDR_SETUP(ADDR_SETUP), .DATA_SETUP(DATA_SETUP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .refreshReq(refreshReq),
    .strobes(strobes), .page(page), .col(col), .row(row),
    .busy(busy), .done(done)
  );

  fbr_datapath #(
    .COLS(COLS), .PAGES(PAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .page(page), .col(col), .row(row),
    .ramAddr(ramAddr), .ramRdEn(ramRdEn), .ramRdData(ramRdData),
    .lcdCsN(lcdCsN), .lcdDc(lcdDc), .lcdWrN(lcdWrN), .lcdData(lcdData)
  );

endmodule

// File: rtl/fbr_checker.sv
module fbr_checker #(
  parameter int ADDR_SETUP = 10,
  parameter int DATA_SETUP = 10
) (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       lcdCsN,
  input logic       lcdDc,
  input logic       lcdWrN,
  input logic [7:0] lcdData
);

  logic [15:0] setupCnt;
  logic [15:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupCnt <= '0;
      lowCnt   <= '0;
    end else begin
      setupCnt <= lcdCsN ? 16'd0 : (lcdWrN ? setupCnt + 16'd1 : setupCnt);
      lowCnt   <= lcdWrN ? 16'd0 : lowCnt + 16'd1;
    end
  end

  // R6: strobe only inside chip select
  a_r6_strobe_in_select: assert property (@(posedge clk) disable iff (!rstN)
    !lcdWrN |-> !lcdCsN);

  // R6: bus content frozen for the whole transfer
  a_r6_bus_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!lcdCsN && $past(!lcdCsN)) |-> ($stable(lcdData) && $stable(lcdDc)));

  // R6: chip select still held as the strobe rises
  a_r6_hold_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lcdWrN) |-> !lcdCsN);

  // R6: setup phase length
  a_r6_setup_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lcdWrN) |-> (setupCnt == 16'(ADDR_SETUP)));

  // R6: strobe low length
  a_r6_strobe_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lcdWrN) |-> (lowCnt == 16'(DATA_SETUP)));

  // R7: done is a single pulse followed by idle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R7: no bus activity outside a refresh
  a_r7_bus_idle_when_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> lcdCsN);

endmodule

bind fb_page_refresh fbr_checker #(
  .ADDR_SETUP(ADDR_SETUP), .DATA_SETUP(DATA_SETUP)
) u_fbr_checker (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .lcdCsN(lcdCsN), .lcdDc(lcdDc), .lcdWrN(lcdWrN), .lcdData(lcdData)
);

// File: tb/fb_page_refresh_bench.sv
`timescale 1ns/1ps
module fb_page_refresh_bench;

  localparam int COLS     = 128;
  localparam int PAGES    = 16;
  localparam int AS       = 3;
  localparam int DS       = 2;
  localparam int PER_PAGE = COLS + 3;
  localparam int TOTAL    = PAGES * PER_PAGE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refreshReq = 1'b0;
  logic        busy, done;
  logic [13:0] ramAddr;
  logic        ramRdEn;
  logic [7:0]  ramRdData = 8'h00;
  logic        lcdCsN, lcdDc, lcdWrN;
  logic [7:0]  lcdData;

  int checks = 0;
  int failures = 0;
  int pat = 1;
  int byteIdx = 0;
  int doneCount = 0;
  int setupCnt = 0;
  int strobeCnt = 0;
  logic prevWr = 1'b1;
  logic prevDone = 1'b0;
  logic idleNext = 1'b0;
  logic monOn = 1'b0;

  always #2.5 clk = ~clk;

  fb_page_refresh #(
    .COLS(COLS), .PAGES(PAGES), .ADDR_SETUP(AS), .DATA_SETUP(DS)
  ) u_fb_page_refresh (
    .clk(clk), .rstN(rstN), .refreshReq(refreshReq),
    .busy(busy), .done(done), .ramAddr(ramAddr), .ramRdEn(ramRdEn),
    .ramRdData(ramRdData), .lcdCsN(lcdCsN), .lcdDc(lcdDc),
    .lcdWrN(lcdWrN), .lcdData(lcdData)
  );

  function automatic logic [7:0] pixVal(int addr, int p);
    int r = addr / COLS;
    int c = addr % COLS;
    case (p)
      1:       return (((r ^ c) & 3) == 0) ? 8'(1 << (c % 8)) : 8'h00;
      2:       return (r == c || r == COLS - 1 - c) ? 8'hFF : 8'h00;
      default: return (((r * 7 + c) % 3) == 0) ? 8'h40 : 8'h00;
    endcase
  endfunction

  // Expected {registerSelect, data} for byte number idx of a frame.
  function automatic logic [8:0] expByte(int idx, int p);
    int pg = idx / PER_PAGE;
    int k  = idx % PER_PAGE;
    logic [7:0] b;
    if (k == 0) return {1'b0, 8'hB0 | 8'(pg)};
    if (k == 1) return 9'h010;
    if (k == 2) return 9'h000;
    for (int i = 0; i < 8; i++)
      b[7 - i] = (pixVal((pg * 8 + i) * COLS + (k - 3), p) != 8'h00);
    return {1'b1, b};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Framebuffer model: one clock of read latency.
  always @(posedge clk) if (ramRdEn) ramRdData <= pixVal(int'(ramAddr), pat);

  // Bus monitor, sampled between clock edges.
  always @(negedge clk) begin
    if (monOn) begin
      if (idleNext) begin
        check(!busy, "R7 busy low after done", busy, 0);
        idleNext = 1'b0;
      end
      if (!lcdCsN && lcdWrN && prevWr) setupCnt++;
      if (!lcdWrN) begin
        strobeCnt++;
        if (lcdCsN) check(0, "R6 strobe outside select", lcdCsN, 0);
      end
      if (lcdWrN && !prevWr) begin
        logic [8:0] e;
        check(!lcdCsN, "R6 select held at strobe rise", lcdCsN, 0);
        check(setupCnt == AS, "R6 setup clocks", setupCnt, AS);
        check(strobeCnt == DS, "R6 strobe clocks", strobeCnt, DS);
        if (byteIdx >= TOTAL) begin
          check(0, "R3 extra byte in frame", byteIdx, TOTAL - 1);
        end else begin
          e = expByte(byteIdx, pat);
          if (e[8] == 1'b0)
            check({lcdDc, lcdData} == e, "R2 command byte", {lcdDc, lcdData}, e);
          else
            check({lcdDc, lcdData} == e, "R3 R4 R5 data byte", {lcdDc, lcdData}, e);
        end
        byteIdx++;
      end
      if (lcdCsN) begin
        setupCnt  = 0;
        strobeCnt = 0;
      end
      if (done) begin
        check(!prevDone, "R7 done one clock", prevDone, 0);
        check(byteIdx == TOTAL, "R7 bytes before done", byteIdx, TOTAL);
        byteIdx = 0;
        doneCount++;
        idleNext = 1'b1;
      end
      prevWr   = lcdWrN;
      prevDone = done;
    end
  end

  task automatic pulseReq();
    @(negedge clk) refreshReq = 1'b1;
    @(negedge clk) refreshReq = 1'b0;
  endtask

  task automatic waitDone(input int target);
    while (doneCount < target) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(lcdCsN && lcdWrN, "R1 bus idle in reset", {lcdCsN, lcdWrN}, 3);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(lcdCsN == 1'b1, "R1 chip select idle", lcdCsN, 1);
    check(lcdWrN == 1'b1, "R1 strobe idle", lcdWrN, 1);
    check(busy == 1'b0, "R1 busy low", busy, 0);
    check(done == 1'b0, "R1 done low", done, 0);
    monOn = 1'b1;
  endtask

  // Single frame with single-bit nonzero pixel values (R4, R5).
  task automatic testSingleFrame();
    pat = 1;
    @(negedge clk) refreshReq = 1'b1;
    @(negedge clk) refreshReq = 1'b0;
    check(busy == 1'b0, "R7 busy not yet high", busy, 0);
    @(negedge clk);
    check(busy == 1'b1, "R7 busy two clocks after request", busy, 1);
    waitDone(1);
    repeat (4) @(negedge clk);
    check(doneCount == 1, "R8 one frame per request", doneCount, 1);
    check(busy == 1'b0, "R7 idle after frame", busy, 0);
  endtask

  // Requests during a frame coalesce into exactly one more frame (R8).
  task automatic testQueuedFrame();
    pat = 2;
    pulseReq();
    repeat (500) @(negedge clk);
    pulseReq();
    repeat (700) @(negedge clk);
    pulseReq();
    waitDone(2);
    pat = 3;
    waitDone(3);
    repeat (300) @(negedge clk);
    check(doneCount == 3, "R8 exactly one queued frame", doneCount, 3);
    check(busy == 1'b0, "R8 idle after queued frame", busy, 0);
    check(lcdCsN == 1'b1, "R8 bus quiet after queued frame", lcdCsN, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    testSingleFrame();
    testQueuedFrame();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule